// File: doc/BRIEF.md
# Keyboard Host Port Pair

This block sits between a key event source and the host's I/O read path. It presents two byte-wide read ports. Port select 0 returns the keycode held in a latch. Port select 1 returns a status byte: shift state, key type, whether a key is down, and a flag that says a new keycode is waiting to be fetched. Scanning the key matrix happens elsewhere; this block only receives finished events, each carrying a code, a shift flag, a function-key flag and a pressed/released flag.

Firmware tests the keyboard path at power-up. It expects a fixed four-read exchange before the ports behave normally. After reset the block answers that exchange itself. Key events that arrive during the exchange are merged into a holding register and take effect when the exchange ends.

Read data is combinational from the current state and the port select. Side effects take place at the clock edge that ends a strobed read.

Top module: `kbd_port_if`

## Requirements
- R1: In normal mode a read with port select 0 returns the latched keycode, zero-extended to 8 bits. After reset the latch holds 0.
- R2: A press whose code differs from the latched one replaces the latch. A press of the same code, or any release, leaves the latch unchanged.
- R3: Status bit 7 equals the shift flag of the most recent accepted event, whether press or release.
- R4: Status bit 6 equals the function-key flag of the most recent press. Status bit 3 is 0 while the most recent event was a press, and 1 after a release or after reset.
- R5: Status bits 5, 4, 2 and 1 always read 0.
- R6: After reset the block accepts only this order of reads: status returns 1, then code returns 3, then status returns 1, then status returns 0. Normal mode begins after the fourth read. During the sequence, a read of the port not expected next returns 0 and does not advance the sequence.
- R7: Status bit 0 becomes 1 on a press. In normal mode a port-0 read clears it. If a press and a port-0 read happen in the same cycle, the bit ends at 1.
- R8: A repeated press of the latched code sets status bit 0 again.
- R9: Events during the sequence do not change the visible state. When the final sequence read completes, the held events are applied, including any event in that same cycle. The held shift and down state come from the latest event. The code and function flag come from the latest press, and status bit 0 is set if any press was held.
- R10: Asserting reset in normal mode restarts the diagnostic sequence and clears the key state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Key event present this cycle |
| ev_code | input | CODE_W | Key code of the event |
| ev_shift | input | 1 | Shift held during the event |
| ev_func | input | 1 | Event key is a function key |
| ev_down | input | 1 | 1 = press, 0 = release |
| rd_stb | input | 1 | Host read strobe |
| rd_port | input | 1 | Port select: 0 = code, 1 = status |
| rd_data | output | 8 | Read data for the selected port |

## Verification
The bench builds the block with CODE_W = 4. At that width all 16 codes can be swept exhaustively, each combined with every shift and function-flag setting, for both presses and releases. The small code space also lets repeated presses of each code and collisions between a press and a read be tried on every value. The diagnostic exchange is run with out-of-order reads, with events held during it, and with an event that lands in its final cycle.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [2:0] {
    DG_STAT_A = 3'd0,
    DG_CODE   = 3'd1,
    DG_STAT_B = 3'd2,
    DG_STAT_Z = 3'd3,
    DG_RUN    = 3'd4
  } diag_e;

  localparam int ST_SHIFT = 7;
  localparam int ST_FUNC  = 6;
  localparam int ST_UP    = 3;
  localparam int ST_REQ   = 0;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/kbd_diag_seq.sv
module kbd_diag_seq
  import kbd_pkg::*;
#(
  parameter logic [7:0] STAT_ONE = 8'd1,
  parameter logic [7:0] CODE_VAL = 8'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic       rd_port,
  output logic       active,
  output logic       done,
  output diag_e      state,
  output logic [7:0] rd_data
);
  diag_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    rd_data = 8'd0;
    case (st_q)
      DG_STAT_A: if (rd_port) begin
        rd_data = STAT_ONE;
        if (rd_stb) st_d = DG_CODE;
      end
      DG_CODE: if (!rd_port) begin
        rd_data = CODE_VAL;
        if (rd_stb) st_d = DG_STAT_B;
      end
      DG_STAT_B: if (rd_port) begin
        rd_data = STAT_ONE;
        if (rd_stb) st_d = DG_STAT_Z;
      end
      DG_STAT_Z: if (rd_port && rd_stb) st_d = DG_RUN;
      default: st_d = DG_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DG_STAT_A;
    else        st_q <= st_d;
  end

  assign active = (st_q != DG_RUN);
  assign done   = (st_q == DG_STAT_Z) && rd_stb && rd_port;
  assign state  = st_q;
endmodule

// File: rtl/kbd_evt_hold.sv
module kbd_evt_hold #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_en,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              ev_shift,
  input  logic              ev_func,
  input  logic              ev_down,
  output logic [CODE_W-1:0] m_code,
  output logic              m_func,
  output logic              m_shift,
  output logic              m_down,
  output logic              m_press
);
  logic [CODE_W-1:0] code_q;
  logic              func_q, shift_q, down_q, press_q;

  always_comb begin
    m_code  = code_q;
    m_func  = func_q;
    m_shift = shift_q;
    m_down  = down_q;
    m_press = press_q;
    if (ev_valid) begin
      m_shift = ev_shift;
      m_down  = ev_down;
      if (ev_down) begin
        m_code  = ev_code;
        m_func  = ev_func;
        m_press = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      func_q  <= 1'b0;
      shift_q <= 1'b0;
      down_q  <= 1'b0;
      press_q <= 1'b0;
    end else if (hold_en) begin
      code_q  <= m_code;
      func_q  <= m_func;
      shift_q <= m_shift;
      down_q  <= m_down;
      press_q <= m_press;
    end
  end
endmodule

// File: rtl/kbd_key_latch.sv
module kbd_key_latch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_apply,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              ev_shift,
  input  logic              ev_func,
  input  logic              ev_down,
  input  logic              pend_load,
  input  logic [CODE_W-1:0] p_code,
  input  logic              p_func,
  input  logic              p_shift,
  input  logic              p_down,
  input  logic              p_press,
  input  logic              rd_clr,
  output logic [CODE_W-1:0] code_q,
  output logic              func_q,
  output logic              shift_q,
  output logic              down_q,
  output logic              req_q
);
  logic [CODE_W-1:0] code_d;
  logic              func_d, shift_d, down_d, req_d;

  always_comb begin
    code_d  = code_q;
    func_d  = func_q;
    shift_d = shift_q;
    down_d  = down_q;
    req_d   = req_q;
    if (rd_clr) req_d = 1'b0;
    if (pend_load) begin
      shift_d = p_shift;
      down_d  = p_down;
      if (p_press) begin
        if (p_code != code_q) code_d = p_code;
        func_d = p_func;
        req_d  = 1'b1;
      end
    end else if (ev_apply) begin
      shift_d = ev_shift;
      down_d  = ev_down;
      if (ev_down) begin
        if (ev_code != code_q) code_d = ev_code;
        func_d = ev_func;
        req_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      func_q  <= 1'b0;
      shift_q <= 1'b0;
      down_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      code_q  <= code_d;
      func_q  <= func_d;
      shift_q <= shift_d;
      down_q  <= down_d;
      req_q   <= req_d;
    end
  end
endmodule

// File: rtl/kbd_port_if.sv
module kbd_port_if
  import kbd_pkg::*;
#(
  parameter int         CODE_W   = 8,
  parameter logic [7:0] DIAG_ST  = 8'd1,
  parameter logic [7:0] DIAG_CD  = 8'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              ev_shift,
  input  logic              ev_func,
  input  logic              ev_down,
  input  logic              rd_stb,
  input  logic              rd_port,
  output logic [7:0]        rd_data
);
  logic              rst_sync_n;
  logic              diag_active, diag_done;
  diag_e             diag_st;
  logic [7:0]        diag_data;
  logic [CODE_W-1:0] m_code, code_q;
  logic              m_func, m_shift, m_down, m_press;
  logic              func_q, shift_q, down_q, req_q;
  logic [7:0]        code_byte, stat_byte;

  kbd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kbd_diag_seq #(.STAT_ONE(DIAG_ST), .CODE_VAL(DIAG_CD)) u_diag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_stb  (rd_stb),
    .rd_port (rd_port),
    .active  (diag_active),
    .done    (diag_done),
    .state   (diag_st),
    .rd_data (diag_data)
  );

  kbd_evt_hold #(.CODE_W(CODE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hold_en  (diag_active),
    .ev_valid (ev_valid),
    .ev_code  (ev_code),
    .ev_shift (ev_shift),
    .ev_func  (ev_func),
    .ev_down  (ev_down),
    .m_code   (m_code),
    .m_func   (m_func),
    .m_shift  (m_shift),
    .m_down   (m_down),
    .m_press  (m_press)
  );

  kbd_key_latch #(.CODE_W(CODE_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev_apply  (!diag_active && ev_valid),
    .ev_code   (ev_code),
    .ev_shift  (ev_shift),
    .ev_func   (ev_func),
    .ev_down   (ev_down),
    .pend_load (diag_done),
    .p_code    (m_code),
    .p_func    (m_func),
    .p_shift   (m_shift),
    .p_down    (m_down),
    .p_press   (m_press),
    .rd_clr    (!diag_active && rd_stb && !rd_port),
    .code_q    (code_q),
    .func_q    (func_q),
    .shift_q   (shift_q),
    .down_q    (down_q),
    .req_q     (req_q)
  );

  always_comb begin
    code_byte = 8'd0;
    code_byte[CODE_W-1:0] = code_q;
    stat_byte = 8'd0;
    stat_byte[ST_SHIFT] = shift_q;
    stat_byte[ST_FUNC]  = func_q;
    stat_byte[ST_UP]    = !down_q;
    stat_byte[ST_REQ]   = req_q;
    if (diag_active)  rd_data = diag_data;
    else if (rd_port) rd_data = stat_byte;
    else              rd_data = code_byte;
  end
endmodule

// File: rtl/kbd_port_if_chk.sv
module kbd_port_if_chk
  import kbd_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              diag_active,
  input logic              diag_done,
  input diag_e             diag_st,
  input logic              rd_stb,
  input logic              rd_port,
  input logic [7:0]        rd_data,
  input logic              ev_valid,
  input logic              ev_down,
  input logic [CODE_W-1:0] ev_code,
  input logic [CODE_W-1:0] code_q,
  input logic              down_q,
  input logic              req_q
);
  p_diag_first_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (diag_st == DG_STAT_A && rd_port) |-> rd_data == 8'd1);

  p_zero_bits_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!diag_active && rd_port) |-> (rd_data[5:4] == 2'b00 && rd_data[2:1] == 2'b00));

  p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!diag_active && rd_stb && !rd_port && !ev_valid) |=> !req_q);

  p_press_req_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!diag_active && ev_valid && ev_down) |=> (req_q && code_q == $past(ev_code)));

  p_held_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (diag_active && !diag_done) |=> $stable(code_q));

  p_down_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!diag_active && ev_valid) |=> down_q == $past(ev_down));
endmodule

bind kbd_port_if kbd_port_if_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .diag_active (diag_active),
  .diag_done   (diag_done),
  .diag_st     (diag_st),
  .rd_stb      (rd_stb),
  .rd_port     (rd_port),
  .rd_data     (rd_data),
  .ev_valid    (ev_valid),
  .ev_down     (ev_down),
  .ev_code     (ev_code),
  .code_q      (code_q),
  .down_q      (down_q),
  .req_q       (req_q)
);

// File: tb/sim_kbd_port_if.sv
module sim_kbd_port_if;
  localparam int CW = 4;

  logic          clk, rst_n;
  logic          ev_valid, ev_shift, ev_func, ev_down, rd_stb, rd_port;
  logic [CW-1:0] ev_code;
  logic [7:0]    rd_data;
  int            total, bad;
  logic [7:0]    d;

  kbd_port_if #(.CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_shift(ev_shift), .ev_func(ev_func), .ev_down(ev_down),
    .rd_stb(rd_stb), .rd_port(rd_port), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] stat(input logic s, input logic f,
                                      input logic dn, input logic rq);
    stat = {s, f, 2'b00, !dn, 2'b00, rq};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  // One cycle: optional event and optional read; returns read data sampled before the edge.
  task automatic cyc(input logic ev, input logic [CW-1:0] c, input logic s,
                     input logic f, input logic dn, input logic rs,
                     input logic p, output logic [7:0] q);
    @(negedge clk);
    ev_valid = ev; ev_code = c; ev_shift = s; ev_func = f; ev_down = dn;
    rd_stb = rs; rd_port = p;
    #1 q = rd_data;
    @(posedge clk);
    #1;
    ev_valid = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic rd(input logic p, output logic [7:0] q);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, p, q);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pass_diag;
    logic [7:0] q;
    rd(1'b1, q); chk("R6 diag status 1", q, 8'd1);
    rd(1'b0, q); chk("R6 diag code 3", q, 8'd3);
    rd(1'b1, q); chk("R6 diag status 1 again", q, 8'd1);
    rd(1'b1, q); chk("R6 diag status 0", q, 8'd0);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] prev;
    total = 0; bad = 0;
    ev_valid = 0; ev_code = '0; ev_shift = 0; ev_func = 0; ev_down = 0;
    rd_stb = 0; rd_port = 0;
    do_reset();

    // R6 with out-of-order reads, R9 events held during sequence
    rd(1'b0, d); chk("R6 wrong port first", d, 8'd0);
    rd(1'b1, d); chk("R6 status 1", d, 8'd1);
    rd(1'b1, d); chk("R6 wrong port in code step", d, 8'd0);
    cyc(1'b1, 4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, d);
    chk("R9 held press not visible", d, 8'd3);
    cyc(1'b1, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, d); // release held
    rd(1'b0, d); chk("R6 code 3", d, 8'd3);
    rd(1'b0, d); chk("R6 wrong port in status step", d, 8'd0);
    rd(1'b1, d); chk("R6 status 1 second", d, 8'd1);
    rd(1'b1, d); chk("R6 status 0 final", d, 8'd0);
    rd(1'b1, d); chk("R9 held applied status", d, stat(1, 1, 0, 1));
    rd(1'b0, d); chk("R9 held code", d, 8'd5);
    rd(1'b1, d); chk("R7 cleared by code read", d, stat(1, 1, 0, 0));

    // R10 reset restarts sequence; R1 reset code
    do_reset();
    rd(1'b1, d); chk("R10 sequence restarts", d, 8'd1);
    rd(1'b0, d); rd(1'b1, d); rd(1'b1, d);
    rd(1'b1, d); chk("R10 R4 R5 reset status", d, stat(0, 0, 0, 0));
    rd(1'b0, d); chk("R1 reset code", d, 8'd0);

    // Exhaustive sweep: codes x shift x func, press then release
    prev = '0;
    for (int c = 0; c < 16; c++) begin
      for (int sf = 0; sf < 4; sf++) begin
        logic s, f;
        s = sf[0]; f = sf[1];
        cyc(1'b1, CW'(c), s, f, 1'b1, 1'b0, 1'b0, d);
        rd(1'b1, d); chk("R3 R4 R7 press status", d, stat(s, f, 1, 1));
        rd(1'b0, d); chk("R1 R2 press code", d, 8'(c));
        cyc(1'b1, CW'((c + 7) % 16), !s, !f, 1'b0, 1'b0, 1'b0, d);
        rd(1'b1, d); chk("R3 R4 release status", d, stat(!s, f, 0, 0));
        rd(1'b0, d); chk("R2 release keeps code", d, 8'(c));
        cyc(1'b1, CW'(c), s, f, 1'b1, 1'b0, 1'b0, d);
        rd(1'b1, d); chk("R8 repeat sets request", d, stat(s, f, 1, 1));
        rd(1'b0, d); chk("R2 R8 same code kept", d, 8'(c));
        prev = CW'(c);
      end
      // press collides with code read: old code returned, request stays set
      cyc(1'b1, CW'((c + 1) % 16), 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, d);
      chk("R7 collision read old code", d, 8'(prev));
      rd(1'b1, d); chk("R7 press wins over clear", d, stat(0, 0, 1, 1));
      rd(1'b0, d); chk("R2 different code replaces", d, 8'((c + 1) % 16));
    end

    // R9 event in final sequence cycle is applied
    do_reset();
    rd(1'b1, d); rd(1'b0, d); rd(1'b1, d);
    cyc(1'b1, 4'd9, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, d);
    chk("R6 final read value", d, 8'd0);
    rd(1'b1, d); chk("R9 last-cycle event status", d, stat(0, 1, 1, 1));
    rd(1'b0, d); chk("R9 last-cycle event code", d, 8'd9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule